// File: doc/BRIEF.md
# Fractional-N Modulus Accumulator

This block produces one divide value per reference period for a fractional-N frequency divider. An integer value N and a small numerator F come in. Over time the divide values average to N + F/M, where M is a modulus of 15 or 16 chosen by one pin. At each reference strobe the numerator is added to a running remainder. When the remainder reaches M, that period's divide value is N+1 and a carry flag is raised. Otherwise the value is N.

The output side is a valid-only stream. Each reference strobe yields exactly one valid beat one clock later. There is no ready input, because a reference period cannot be stalled, so the consumer must take every beat. Between beats the divide value holds and the carry flag stays low. The enable, modulus select and error flag are plain level signals.

Top module: `fracn_mod_acc`

## Requirements
- R1: While reset is high and in the first cycle after it, `div_o`, `div_valid_o`, `carry_o` and `cfg_err_o` are all zero, and the remainder is zero.
- R2: `mod15_i` = 1 selects modulus M = 15 and `mod15_i` = 0 selects M = 16.
- R3: On an enabled strobe the numerator is added to the remainder. If the sum is at least M, M is subtracted and the divide value is N+1; otherwise it is N. The result appears on `div_o` in the cycle after the strobe.
- R4: Starting from a zero remainder, strobe k (counting from 1) carries exactly when floor(k·F/M) > floor((k−1)·F/M). Any M consecutive strobes therefore give exactly F carries.
- R5: `div_valid_o` is high in the cycle after each strobe and low in every other cycle. There is no back-pressure.
- R6: While `en_i` is low, `carry_o` is low and `div_o` takes N every clock. The remainder is cleared to zero, so the next enabled period starts from zero.
- R7: A numerator of 15 with M = 15 is used as 14.
- R8: `cfg_err_o` goes high one clock after the block is enabled with M = 15 and numerator 15. It then stays high until reset.
- R9: `div_o` is one bit wider than N, so N = 1023 with a carry gives 1024 and does not wrap.
- R10: `carry_o` is high only together with `div_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_stb_i | input | 1 | One-cycle strobe per reference period |
| en_i | input | 1 | Fractional accumulation enable |
| mod15_i | input | 1 | Modulus select: 1 gives 15, 0 gives 16 |
| n_i | input | N_W | Integer divide value N |
| num_i | input | FRAC_W | Fraction numerator F |
| div_o | output | N_W+1 | Divide value for the period |
| div_valid_o | output | 1 | Beat valid, one cycle after a strobe |
| carry_o | output | 1 | The beat used N+1 |
| cfg_err_o | output | 1 | Sticky flag for numerator 15 with modulus 15 |

## Verification
A wrong remainder is not visible directly. It shows up as a carry that comes one or more strobes early or late compared with the floor(k·F/M) schedule, and it shows up on the first beat where the schedules differ. A remainder that was not cleared while the block was disabled shows on the first enabled strobe: with F = 8 and M = 16 that strobe carries when it should not. A wrong modulus or a missing clamp changes the number of carries in one full period, which the sweep over every legal numerator and both moduli counts.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  typedef enum logic {
    MOD_FULL  = 1'b0,
    MOD_SHORT = 1'b1
  } mod_sel_e;

  // modulus for a numerator width w: 2^w, or 2^w-1 in the short mode
  function automatic int unsigned modulus_of(mod_sel_e s, int unsigned w);
    int unsigned full;
    full = 32'd1 << w;
    return (s == MOD_SHORT) ? full - 32'd1 : full;
  endfunction
endpackage

// File: rtl/fracn_num_guard.sv
module fracn_num_guard #(
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              mod_m1_i,
  input  logic [FRAC_W-1:0] num_i,
  output logic [FRAC_W-1:0] num_o,
  output logic              err_o
);
  localparam logic [FRAC_W-1:0] ALL_ONES = {FRAC_W{1'b1}};

  logic illegal;
  logic err_q;

  always_comb begin
    illegal = mod_m1_i && (num_i == ALL_ONES);
    num_o   = illegal ? ALL_ONES - FRAC_W'(1) : num_i;   // R7 clamp
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                err_q <= 1'b0;
    else if (en_i && illegal) err_q <= 1'b1;
  end

  assign err_o = err_q;

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    err_q |=> err_q);
endmodule

// File: rtl/fracn_phase.sv
module fracn_phase #(
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  input  logic              clr_i,
  input  logic              mod_m1_i,
  input  logic [FRAC_W-1:0] num_i,
  output logic              wrap_o
);
  import fracn_pkg::*;
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  modv;
  logic [SUM_W-1:0]  reduced;

  always_comb begin
    modv    = SUM_W'(modulus_of(mod_sel_e'(mod_m1_i), FRAC_W));   // R2
    sum     = {1'b0, acc_q} + {1'b0, num_i};
    wrap_o  = (sum >= modv);
    reduced = sum - modv;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) acc_q <= '0;
    else if (adv_i)     acc_q <= wrap_o ? reduced[FRAC_W-1:0] : sum[FRAC_W-1:0];
  end

  // R3: after an advance the remainder lies below the modulus in force
  p_acc_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(adv_i) |-> ({1'b0, acc_q} < $past(modv)));
endmodule

// File: rtl/fracn_out_stage.sv
module fracn_out_stage #(
  parameter int N_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           stb_i,
  input  logic           en_i,
  input  logic           wrap_i,
  input  logic [N_W-1:0] n_i,
  output logic [N_W:0]   div_o,
  output logic           valid_o,
  output logic           carry_o
);
  logic step;

  always_comb step = stb_i && en_i && wrap_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_o   <= '0;
      valid_o <= 1'b0;
      carry_o <= 1'b0;
    end else begin
      valid_o <= stb_i;
      carry_o <= step;
      if (stb_i || !en_i) div_o <= {1'b0, n_i} + (N_W+1)'(step);
    end
  end

  p_carry_valid_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_o |-> valid_o);
endmodule

// File: rtl/fracn_mod_acc.sv
module fracn_mod_acc #(
  parameter int N_W    = 10,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ref_stb_i,
  input  logic              en_i,
  input  logic              mod15_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [FRAC_W-1:0] num_i,
  output logic [N_W:0]      div_o,
  output logic              div_valid_o,
  output logic              carry_o,
  output logic              cfg_err_o
);
  logic [FRAC_W-1:0] num_eff;
  logic              wrap;
  logic              adv;

  always_comb adv = ref_stb_i && en_i;

  fracn_num_guard #(.FRAC_W(FRAC_W)) u_guard (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .mod_m1_i(mod15_i),
    .num_i(num_i), .num_o(num_eff), .err_o(cfg_err_o)
  );

  fracn_phase #(.FRAC_W(FRAC_W)) u_phase (
    .clk_i(clk_i), .rst_i(rst_i), .adv_i(adv), .clr_i(!en_i),
    .mod_m1_i(mod15_i), .num_i(num_eff), .wrap_o(wrap)
  );

  fracn_out_stage #(.N_W(N_W)) u_out (
    .clk_i(clk_i), .rst_i(rst_i), .stb_i(ref_stb_i), .en_i(en_i),
    .wrap_i(wrap), .n_i(n_i), .div_o(div_o), .valid_o(div_valid_o),
    .carry_o(carry_o)
  );

  p_valid_follows_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ref_stb_i |=> div_valid_o);
  p_valid_only_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !ref_stb_i |=> !div_valid_o);
  p_disabled_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!carry_o && div_o == {1'b0, $past(n_i)}));
  p_div_value_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_valid_o && $past(en_i)) |-> (div_o == {1'b0, $past(n_i)} + (N_W+1)'(carry_o)));
  p_err_raise_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && mod15_i && (&num_i)) |=> cfg_err_o);
endmodule

// File: tb/fracn_mod_acc_tb.sv
module fracn_mod_acc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_W = 10;
  localparam int FRAC_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic en = 1'b0;
  logic mod15 = 1'b0;
  logic [N_W-1:0] n = '0;
  logic [FRAC_W-1:0] num = '0;
  logic [N_W:0] div;
  logic valid, carry, cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_mod_acc #(.N_W(N_W), .FRAC_W(FRAC_W)) u_dut (
    .clk_i(clk), .rst_i(rst), .ref_stb_i(stb), .en_i(en), .mod15_i(mod15),
    .n_i(n), .num_i(num), .div_o(div), .div_valid_o(valid),
    .carry_o(carry), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one strobe; returns the beat seen one clock later
  task automatic pulse(output bit c, output int d);
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    chk(valid == 1'b1, "R5 valid after strobe", int'(valid), 1);
    c = carry;
    d = int'(div);
  endtask

  task automatic clear_acc();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    bit c;
    int d;
    int cnt;
    repeat (3) @(negedge clk);
    chk(div == 0 && !valid && !carry && !cfg_err, "R1 outputs in reset", int'(div), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(div == 0 && !valid && !carry && !cfg_err, "R1 outputs after reset", int'(carry), 0);

    // R2 R3 R4: every legal numerator under both moduli
    for (int sel = 0; sel < 2; sel++) begin
      int m;
      m = (sel == 1) ? 15 : 16;
      for (int f = 0; f < m; f++) begin
        mod15 = sel[0];
        num = FRAC_W'(f);
        n = N_W'(100 + 37 * f + sel);
        clear_acc();
        cnt = 0;
        for (int k = 1; k <= m; k++) begin
          bit ec;
          ec = ((k * f) / m) != (((k - 1) * f) / m);
          pulse(c, d);
          cnt += int'(c);
          chk(c == ec, $sformatf("R4 carry M=%0d F=%0d k=%0d", m, f, k), int'(c), int'(ec));
          chk(d == int'(n) + int'(ec), "R3 divide value", d, int'(n) + int'(ec));
        end
        chk(cnt == f, $sformatf("R2 R4 carries per period M=%0d", m), cnt, f);
      end
    end

    // R5 R10: gap cycle after a beat
    @(negedge clk);
    chk(!valid && !carry, "R5 R10 quiet between strobes", int'(valid), 0);

    // R6: disabled holds carry low, tracks N, clears remainder
    mod15 = 1'b0; num = 4'd8; n = 10'd300;
    clear_acc();
    pulse(c, d);                     // remainder now 8
    @(negedge clk); en = 1'b0; n = 10'd411;
    pulse(c, d);
    chk(!c && d == 411, "R6 disabled strobe gives N", d, 411);
    n = 10'd412;
    @(negedge clk); @(negedge clk);
    chk(div == 412 && !carry, "R6 disabled tracks N", int'(div), 412);
    en = 1'b1;
    pulse(c, d);
    chk(!c, "R6 remainder cleared while disabled", int'(c), 0);

    // R9: top value of N with a carry
    n = 10'd1023; num = 4'd15; mod15 = 1'b0;
    clear_acc();
    pulse(c, d);
    chk(!c && d == 1023, "R9 no carry first", d, 1023);
    pulse(c, d);
    chk(c && d == 1024, "R9 no wrap", d, 1024);

    // R7 R8: clamp and sticky error
    @(negedge clk); rst = 1'b1; en = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk(!cfg_err, "R8 clear after reset", int'(cfg_err), 0);
    mod15 = 1'b1; num = 4'd15; n = 10'd50;
    clear_acc();
    cnt = 0;
    for (int k = 1; k <= 15; k++) begin
      bit ec;
      ec = ((k * 14) / 15) != (((k - 1) * 14) / 15);
      pulse(c, d);
      cnt += int'(c);
      chk(c == ec, "R7 clamped carry pattern", int'(c), int'(ec));
    end
    chk(cnt == 14, "R7 clamped period count", cnt, 14);
    chk(cfg_err, "R8 error raised", int'(cfg_err), 1);
    num = 4'd3; mod15 = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfg_err, "R8 error sticky", int'(cfg_err), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!cfg_err, "R1 R8 error cleared by reset", int'(cfg_err), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule